// File: doc/BRIEF.md
# GPIO Port with Converter Pin Sharing

An eight-bit bidirectional I/O port in which five pins double as inputs to the analog multiplexer of an on-chip A/D converter. The block keeps the output latch and the direction register, and it holds a copy of the converter's enable bit and three-bit channel number. Per-pin output enables and output levels go to the pads. It returns the value software reads from the port, and it gives the converter a one-hot select for its analog multiplexer.

While the converter is enabled and its channel number names a pin-shared input, that pin is taken away from software. Its output driver is turned off at once. Its direction bit is cleared and stays cleared until software writes it again. It also reads back as zero. Channels that have no pin leave the port alone.

Top module: `gpio_adc_port`

## Requirements
- R1: While `rst_n` is low, and straight after reset, `pin_out`, `pin_oe`, `port_rd` and `mux_sel` are all zero. Every pin is an input, the converter is off and the channel is 0.
- R2: A cycle with `dat_we` high loads `dat_wdata` into the output latch. `pin_out` shows the new value after that clock edge.
- R3: A cycle with `dir_we` high loads `dir_wdata` into the direction register, where 1 marks an output. `pin_oe` follows after that edge unless R5 overrides a bit.
- R4: `port_rd` bit i returns the latch bit for an output pin. For an input pin it returns `pin_in` bit i through a two-flop synchronizer, so a pin change reaches `port_rd` after two clock edges.
- R5: Channel-to-pin map: channel 0 goes to pin 6, 1 to pin 5, 2 to pin 4, 3 to pin 3, and 4 to pin 7 (pin 7 is also the high reference input). When the converter is enabled and one of these channels is selected, that pin's `pin_oe` bit is 0 from the edge that writes the control onward.
- R6: The direction bit of a selected shared pin is cleared at the next edge. It stays 0 after the converter is disabled or the channel changes. A direction write that tries to set it while it is still selected has no effect.
- R7: While a shared pin is selected with the converter on, its `port_rd` bit is 0. All other bits read as in R4.
- R8: Channels 5 (internal reference midpoint), 6 (ground) and 7 (reserved) change no pin's output enable, read value or direction bit.
- R9: `mux_sel` has exactly bit `ctl_ch` set when the converter is enabled. It is all zeros when the converter is disabled.
- R10: With the converter disabled, the channel number has no effect on any pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dat_we | input | 1 | Output latch write strobe |
| dat_wdata | input | 8 | Output latch write value |
| dir_we | input | 1 | Direction register write strobe |
| dir_wdata | input | 8 | Direction write value, 1 = output |
| ctl_we | input | 1 | Converter control write strobe |
| ctl_en | input | 1 | Converter enable value |
| ctl_ch | input | 3 | Converter channel number |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| port_rd | output | 8 | Port read data |
| mux_sel | output | 8 | One-hot analog multiplexer select |

## Verification
Register writes show up on `pin_out`, `pin_oe` and `mux_sel` one edge after the write cycle. A selected pin's read mask also appears one edge after the write cycle. The sticky clearing of its direction bit takes effect one edge later still. A pad change needs two edges before it reaches `port_rd`. The bench keeps a behavioural model that advances on the same rising edge as the design. It compares all four outputs at every falling edge, so each result is checked in exactly the cycle it is due. Directed checks at fixed points confirm the channel map, the stickiness and the channels that have no pin.

// File: rtl/gpio_adc_port.sv
module gpio_adc_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dat_we,
  input  logic [7:0] dat_wdata,
  input  logic       dir_we,
  input  logic [7:0] dir_wdata,
  input  logic       ctl_we,
  input  logic       ctl_en,
  input  logic [2:0] ctl_ch,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  output logic [7:0] port_rd,
  output logic [7:0] mux_sel
);

  logic [7:0] dat_q, dir_q, sync1_q, sync2_q, claim;
  logic       en_q;
  logic [2:0] ch_q;

  function automatic logic [7:0] shared_pin(input logic [2:0] ch);
    case (ch)
      3'd0:    shared_pin = 8'b0100_0000;
      3'd1:    shared_pin = 8'b0010_0000;
      3'd2:    shared_pin = 8'b0001_0000;
      3'd3:    shared_pin = 8'b0000_1000;
      3'd4:    shared_pin = 8'b1000_0000;
      default: shared_pin = 8'b0000_0000;
    endcase
  endfunction

  assign claim = en_q ? shared_pin(ch_q) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      en_q  <= 1'b0;
      ch_q  <= '0;
    end else begin
      if (dat_we) dat_q <= dat_wdata;
      if (ctl_we) begin
        en_q <= ctl_en;
        ch_q <= ctl_ch;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else        dir_q <= (dir_we ? dir_wdata : dir_q) & ~claim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign pin_out = dat_q;
  assign pin_oe  = dir_q & ~claim;
  assign port_rd = ((pin_oe & dat_q) | (~pin_oe & sync2_q)) & ~claim;
  assign mux_sel = en_q ? (8'h01 << ch_q) : 8'h00;

  AST_MUX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mux_sel)); // R9
  AST_MUX_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> mux_sel == 8'h00); // R9
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n) dat_we |=> pin_out == $past(dat_wdata)); // R2
  AST_DIR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (claim != 8'h00) |=> (dir_q & $past(claim)) == 8'h00); // R6
  AST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n) (port_rd & claim) == 8'h00); // R7
  AST_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n) (pin_oe & mux_sel[4:0] == 5'd0 ? 8'h00 : pin_oe & claim) == 8'h00); // R5
  AST_NOPIN_CH: assert property (@(posedge clk) disable iff (!rst_n) (en_q && ch_q >= 3'd5) |-> pin_oe == dir_q); // R8
  AST_OFF_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n) !en_q |-> pin_oe == dir_q); // R10

endmodule

// File: tb/gpio_adc_port_test.sv
module gpio_adc_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dat_we = 1'b0, dir_we = 1'b0, ctl_we = 1'b0, ctl_en = 1'b0;
  logic [7:0] dat_wdata = '0, dir_wdata = '0, pin_in = '0;
  logic [2:0] ctl_ch = '0;
  logic [7:0] pin_out, pin_oe, port_rd, mux_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_adc_port uut (
    .clk(clk), .rst_n(rst_n), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .dir_we(dir_we), .dir_wdata(dir_wdata), .ctl_we(ctl_we), .ctl_en(ctl_en),
    .ctl_ch(ctl_ch), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .port_rd(port_rd), .mux_sel(mux_sel)
  );

  function automatic int pin_of(input int ch);
    case (ch)
      0: return 6;
      1: return 5;
      2: return 4;
      3: return 3;
      4: return 7;
      default: return -1;
    endcase
  endfunction

  logic [7:0] m_dat, m_dir, m_s1, m_s2;
  logic       m_en;
  int         m_ch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dat <= 0; m_dir <= 0; m_s1 <= 0; m_s2 <= 0; m_en <= 0; m_ch <= 0;
    end else begin
      logic [7:0] nd;
      nd = dir_we ? dir_wdata : m_dir;
      if (m_en && pin_of(m_ch) >= 0) nd[pin_of(m_ch)] = 1'b0;
      m_dir <= nd;
      if (dat_we) m_dat <= dat_wdata;
      if (ctl_we) begin m_en <= ctl_en; m_ch <= int'(ctl_ch); end
      m_s1 <= pin_in;
      m_s2 <= m_s1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] mask, eoe, erd, emux;
    mask = (m_en && pin_of(m_ch) >= 0) ? (8'h01 << pin_of(m_ch)) : 8'h00;
    eoe  = m_dir & ~mask;
    erd  = ((eoe & m_dat) | (~eoe & m_s2)) & ~mask;
    emux = m_en ? (8'h01 << m_ch) : 8'h00;
    chk("R2 pin_out", pin_out, m_dat);
    chk("R3 R5 R6 R10 pin_oe", pin_oe, eoe);
    chk("R4 R7 R8 port_rd", port_rd, erd);
    chk("R9 mux_sel", mux_sel, emux);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    dat_we = 0; dir_we = 0; ctl_we = 0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    dat_we = 1; dat_wdata = v; step();
  endtask
  task automatic wr_dir(input logic [7:0] v);
    dir_we = 1; dir_wdata = v; step();
  endtask
  task automatic wr_ctl(input logic en, input int ch);
    ctl_we = 1; ctl_en = en; ctl_ch = 3'(ch); step();
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    @(negedge clk);
    chk("R1 reset pin_oe", pin_oe, 8'h00);
    chk("R1 reset mux_sel", mux_sel, 8'h00);
    chk("R1 reset port_rd", port_rd, 8'h00);
    chk("R1 reset pin_out", pin_out, 8'h00);
    @(negedge clk);
    rst_n = 1;
    step();

    wr_dir(8'hFF);
    wr_dat(8'hA5);
    chk("R2 latch", pin_out, 8'hA5);
    chk("R4 outputs read latch", port_rd, 8'hA5);
    wr_dir(8'h0F);
    chk("R3 direction", pin_oe, 8'h0F);
    pin_in = 8'h3C;
    idle(1);
    chk("R4 one edge not yet", port_rd & 8'hF0, 8'h00);
    idle(1);
    chk("R4 synchronized input", port_rd, 8'h35);

    for (int ch = 0; ch < 8; ch++) begin
      logic [7:0] m;
      m = (pin_of(ch) >= 0) ? (8'h01 << pin_of(ch)) : 8'h00;
      pin_in = 8'hFF;
      wr_dat(8'hFF);
      wr_dir(8'hFF);
      wr_ctl(1, ch);
      chk("R5 driver off", pin_oe, 8'hFF & ~m);
      chk("R9 select", mux_sel, 8'h01 << ch);
      idle(2);
      chk("R7 read mask", port_rd, 8'hFF & ~m);
      if (m == 8'h00) chk("R8 no pin", pin_oe, 8'hFF);
      wr_dir(8'hFF);
      chk("R6 write blocked", pin_oe, 8'hFF & ~m);
      wr_ctl(0, ch);
      idle(1);
      chk("R6 stays cleared", pin_oe, 8'hFF & ~m);
      chk("R9 off", mux_sel, 8'h00);
      wr_dir(8'hFF);
      chk("R10 off no effect", pin_oe, 8'hFF);
    end

    lfsr = 8'h5A;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pin_in = lfsr ^ 8'h33;
      case (i % 5)
        0: begin dat_we = 1; dat_wdata = lfsr; end
        1: begin dir_we = 1; dir_wdata = ~lfsr; end
        2: begin ctl_we = 1; ctl_en = lfsr[0]; ctl_ch = lfsr[3:1]; end
        default: ;
      endcase
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule